// File: doc/BRIEF.md
# Operand-Preserving Hazard Scoreboard

This block guards the issue stage of a simple in-order pipeline that has several functional units of differing latency and no register renaming. For every architectural register it remembers how many issued but unfinished operations still need that register as an input, and whether an unfinished operation is due to write it. An issue request is held back when it would read a value that is not yet written (RAW) or write a register that already has a write pending (WAW). It is also held back when it would overwrite a register that an unfinished operation still reads (WAR). That last rule keeps the inputs of a slow operation, such as a long floating-point divide, in place until it retires. A handler for an exception the operation reports late can then read those inputs again.

Integer and floating-point registers share one address space of `NFILE*NREG_FILE` entries. With the defaults, addresses 0 to 31 are the integer file and 32 to 63 (address bit 5 set) are the floating-point file, so the two files never interact. The unit that finishes an operation hands back its register fields as a completion tag, and that tag releases the matching reader counts and write flag. The stall output and its reason code are computed in the same cycle as the request.

Top module: `sb_war_scoreboard`

## Requirements
- R1: After synchronous reset no register has readers or a pending write, so the first request after reset is accepted whatever registers it names.
- R2: A request whose used source has a pending write stalls, with reason bit 0 (RAW) set.
- R3: A request whose used destination has a pending write stalls, with reason bit 1 (WAW) set.
- R4: A request whose used destination has a nonzero reader count stalls, with reason bit 2 (WAR) set.
- R5: Each accepted read adds one to a register's reader count and each completion source field removes one, so a write stays stalled until the last reader of its destination completes.
- R6: A completion arriving in the same cycle as a request is applied before the request is checked, so a hazard it clears does not stall that request.
- R7: Address bit 5 selects the file (0 integer, 1 floating point), so a hazard on integer register n never stalls an access to floating-point register n.
- R8: An instruction that reads and writes the same register does not stall on itself, and a stalled request changes no tracked state.
- R9: A request stalls with reason bit 3 (FULL) when a used source already has a reader count of at least 2^CNT_W-2 (6 by default), so the counter never wraps.
- R10: A source or destination field whose use bit is low is ignored when hazards are checked and when state is updated.
- R11: While iss_vld is low, stall and every reason bit are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 1 | Issue request present |
| iss_a_use | input | 1 | First source field is used |
| iss_a | input | AW | First source register address |
| iss_b_use | input | 1 | Second source field is used |
| iss_b | input | AW | Second source register address |
| iss_d_use | input | 1 | Destination field is used |
| iss_d | input | AW | Destination register address |
| cmp_vld | input | 1 | Completion tag present |
| cmp_a_use | input | 1 | Completed operation used its first source |
| cmp_a | input | AW | Completed operation first source |
| cmp_b_use | input | 1 | Completed operation used its second source |
| cmp_b | input | AW | Completed operation second source |
| cmp_d_use | input | 1 | Completed operation had a destination |
| cmp_d | input | AW | Completed operation destination |
| stall | output | 1 | Request must be held this cycle |
| stall_why | output | 4 | Reason bits: 0 RAW, 1 WAW, 2 WAR, 3 FULL |

## Verification
The stall and reason outputs depend on the current request, the completion tag in the same cycle and the registered state, with no register in between. An accepted request and a completion change that state at the next rising edge, so they show up in the check of the following cycle. The bench drives each request and completion at the falling edge and compares stall and reason one nanosecond later, before the rising edge. The effect of that cycle's acceptance is therefore judged only by the vector after it. Directed runs then walk a reader count up to its limit and back down one completion per cycle, and compare the output in each of those cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Reason word; raw lands in bit 0, full in bit 3.
  typedef struct packed {
    logic full;
    logic war;
    logic waw;
    logic raw;
  } why_t;
  localparam int unsigned WHY_W = 4;
endpackage

// File: rtl/sb_decode.sv
// Turns one set of operand fields into per-register read hit counts and write hits.
module sb_decode #(
  parameter int unsigned NREG = 64,
  parameter int unsigned AW   = 6
) (
  input  logic                 a_use,
  input  logic [AW-1:0]        a_idx,
  input  logic                 b_use,
  input  logic [AW-1:0]        b_idx,
  input  logic                 d_use,
  input  logic [AW-1:0]        d_idx,
  output logic [NREG-1:0][1:0] rd_n,
  output logic [NREG-1:0]      wr_hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign rd_n[g]   = 2'(a_use && (a_idx == AW'(g))) + 2'(b_use && (b_idx == AW'(g)));
    assign wr_hit[g] = d_use && (d_idx == AW'(g));
  end
endmodule

// File: rtl/sb_entry.sv
// State of one architectural register: reader count and pending-write flag.
module sb_entry #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       acq_rd,
  input  logic             acq_wr,
  input  logic [1:0]       rel_rd,
  input  logic             rel_wr,
  output logic [CNT_W-1:0] eff_cnt,
  output logic             eff_pend
);
  localparam int unsigned CW1  = CNT_W + 1;
  localparam int unsigned MAXC = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  // Completion is applied first so the issue check sees it in the same cycle.
  assign eff_cnt  = cnt_q - CNT_W'(rel_rd);
  assign eff_pend = pend_q & ~rel_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= eff_cnt + CNT_W'(acq_rd);
      pend_q <= eff_pend | acq_wr;
    end
  end

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} >= CW1'(rel_rd)));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, eff_cnt} + CW1'(acq_rd)) <= CW1'(MAXC)));
  a_r3_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !rel_wr) |=> pend_q);
  a_r5_no_rise_without_acquire: assert property (@(posedge clk) disable iff (rst)
    (acq_rd == 2'd0) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/sb_check.sv
// Hazard evaluation for one issue request against post-completion state.
module sb_check import sb_pkg::*; #(
  parameter int unsigned NREG  = 64,
  parameter int unsigned AW    = 6,
  parameter int unsigned CNT_W = 3
) (
  input  logic                      iss_vld,
  input  logic                      a_use,
  input  logic [AW-1:0]             a_idx,
  input  logic                      b_use,
  input  logic [AW-1:0]             b_idx,
  input  logic                      d_use,
  input  logic [AW-1:0]             d_idx,
  input  logic [NREG-1:0][CNT_W-1:0] eff_cnt,
  input  logic [NREG-1:0]           eff_pend,
  output why_t                      why
);
  localparam int unsigned LIM = (1 << CNT_W) - 2;

  always_comb begin
    why.raw  = iss_vld & ((a_use & eff_pend[a_idx]) | (b_use & eff_pend[b_idx]));
    why.waw  = iss_vld & d_use & eff_pend[d_idx];
    why.war  = iss_vld & d_use & (eff_cnt[d_idx] != '0);
    why.full = iss_vld & ((a_use & (eff_cnt[a_idx] >= CNT_W'(LIM))) |
                          (b_use & (eff_cnt[b_idx] >= CNT_W'(LIM))));
  end
endmodule

// File: rtl/sb_war_scoreboard.sv
module sb_war_scoreboard import sb_pkg::*; #(
  parameter int unsigned NREG_FILE = 32,
  parameter int unsigned NFILE     = 2,
  parameter int unsigned CNT_W     = 3,
  localparam int unsigned NREG     = NFILE * NREG_FILE,
  localparam int unsigned AW       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_vld,
  input  logic              iss_a_use,
  input  logic [AW-1:0]     iss_a,
  input  logic              iss_b_use,
  input  logic [AW-1:0]     iss_b,
  input  logic              iss_d_use,
  input  logic [AW-1:0]     iss_d,
  input  logic              cmp_vld,
  input  logic              cmp_a_use,
  input  logic [AW-1:0]     cmp_a,
  input  logic              cmp_b_use,
  input  logic [AW-1:0]     cmp_b,
  input  logic              cmp_d_use,
  input  logic [AW-1:0]     cmp_d,
  output logic              stall,
  output logic [WHY_W-1:0]  stall_why
);
  logic [NREG-1:0][1:0]       iss_rd_n;
  logic [NREG-1:0][1:0]       cmp_rd_n;
  logic [NREG-1:0]            iss_wr;
  logic [NREG-1:0]            cmp_wr;
  logic [NREG-1:0][CNT_W-1:0] eff_cnt;
  logic [NREG-1:0]            eff_pend;
  why_t                       why;
  logic                       accept;

  sb_decode #(.NREG(NREG), .AW(AW)) u_iss_dec (
    .a_use(iss_a_use), .a_idx(iss_a), .b_use(iss_b_use), .b_idx(iss_b),
    .d_use(iss_d_use), .d_idx(iss_d), .rd_n(iss_rd_n), .wr_hit(iss_wr)
  );

  sb_decode #(.NREG(NREG), .AW(AW)) u_cmp_dec (
    .a_use(cmp_vld & cmp_a_use), .a_idx(cmp_a),
    .b_use(cmp_vld & cmp_b_use), .b_idx(cmp_b),
    .d_use(cmp_vld & cmp_d_use), .d_idx(cmp_d),
    .rd_n(cmp_rd_n), .wr_hit(cmp_wr)
  );

  sb_check #(.NREG(NREG), .AW(AW), .CNT_W(CNT_W)) u_chk (
    .iss_vld(iss_vld), .a_use(iss_a_use), .a_idx(iss_a),
    .b_use(iss_b_use), .b_idx(iss_b), .d_use(iss_d_use), .d_idx(iss_d),
    .eff_cnt(eff_cnt), .eff_pend(eff_pend), .why(why)
  );

  assign stall_why = why;
  assign stall     = |why;
  assign accept    = iss_vld & ~stall;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    sb_entry #(.CNT_W(CNT_W)) u_ent (
      .clk(clk), .rst(rst),
      .acq_rd(accept ? iss_rd_n[g] : 2'd0),
      .acq_wr(accept & iss_wr[g]),
      .rel_rd(cmp_rd_n[g]),
      .rel_wr(cmp_wr[g]),
      .eff_cnt(eff_cnt[g]),
      .eff_pend(eff_pend[g])
    );
  end

  a_r4_war_blocks: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && iss_d_use && (eff_cnt[iss_d] != '0)) |-> stall);
  a_r2_raw_blocks: assert property (@(posedge clk) disable iff (rst)
    (iss_vld && iss_a_use && eff_pend[iss_a]) |-> stall);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !iss_vld |-> (stall_why == '0));
  a_r1_clean_after_reset: assert property (@(posedge clk)
    rst |=> (stall_why == '0));
endmodule

// File: tb/sb_war_scoreboard_test.sv
module sb_war_scoreboard_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_vld, iss_a_use, iss_b_use, iss_d_use;
  logic [5:0] iss_a, iss_b, iss_d;
  logic cmp_vld, cmp_a_use, cmp_b_use, cmp_d_use;
  logic [5:0] cmp_a, cmp_b, cmp_d;
  logic stall;
  logic [3:0] stall_why;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sb_war_scoreboard uut (
    .clk(clk), .rst(rst),
    .iss_vld(iss_vld), .iss_a_use(iss_a_use), .iss_a(iss_a),
    .iss_b_use(iss_b_use), .iss_b(iss_b), .iss_d_use(iss_d_use), .iss_d(iss_d),
    .cmp_vld(cmp_vld), .cmp_a_use(cmp_a_use), .cmp_a(cmp_a),
    .cmp_b_use(cmp_b_use), .cmp_b(cmp_b), .cmp_d_use(cmp_d_use), .cmp_d(cmp_d),
    .stall(stall), .stall_why(stall_why)
  );

  localparam logic [5:0] X0 = 6'd0, X2 = 6'd2, X3 = 6'd3, X4 = 6'd4, X5 = 6'd5,
    X7 = 6'd7, X8 = 6'd8, X9 = 6'd9, X10 = 6'd10, X20 = 6'd20;
  localparam logic [5:0] F1 = 6'd33, F2 = 6'd34, F3 = 6'd35, F4 = 6'd36,
    F5 = 6'd37, F6 = 6'd38, F7 = 6'd39, F8 = 6'd40;
  localparam logic [3:0] W_NONE = 4'b0000, W_RAW = 4'b0001, W_WAW = 4'b0010,
    W_WAR = 4'b0100, W_FULL = 4'b1000;
  localparam logic [21:0] C_NONE = 22'd0;

  // {issue[21:0], completion[21:0], expected reason[3:0]}; field order vld,a_use,a,b_use,b,d_use,d
  localparam int NVEC = 16;
  localparam logic [47:0] TBL [NVEC] = '{
    {{1'b1,1'b1,F2,1'b1,F3,1'b1,F1}, C_NONE, W_NONE},
    {{1'b1,1'b1,F3,1'b1,F4,1'b1,F2}, C_NONE, W_WAR},
    {{1'b1,1'b1,F3,1'b1,F4,1'b1,F2}, C_NONE, W_WAR},
    {{1'b1,1'b1,X3,1'b1,X4,1'b1,X2}, C_NONE, W_NONE},
    {{1'b1,1'b1,F1,1'b1,F6,1'b1,F5}, C_NONE, W_RAW},
    {{1'b1,1'b1,F7,1'b1,F8,1'b1,F1}, C_NONE, W_WAW},
    {{1'b1,1'b1,F3,1'b1,F4,1'b1,F2}, {1'b1,1'b1,F2,1'b1,F3,1'b1,F1}, W_NONE},
    {{1'b1,1'b1,X9,1'b1,X9,1'b1,X9}, C_NONE, W_NONE},
    {{1'b1,1'b1,X9,1'b0,X0,1'b1,X10}, C_NONE, W_RAW},
    {{1'b1,1'b0,X2,1'b0,X2,1'b1,X5}, C_NONE, W_NONE},
    {{1'b0,1'b1,X9,1'b0,X0,1'b1,X3}, C_NONE, W_NONE},
    {{1'b1,1'b1,X20,1'b0,X0,1'b0,X3}, C_NONE, W_NONE},
    {{1'b1,1'b1,X2,1'b0,X0,1'b1,X7}, {1'b1,1'b1,X3,1'b1,X4,1'b1,X2}, W_NONE},
    {{1'b1,1'b1,X0,1'b0,X0,1'b1,X3}, C_NONE, W_NONE},
    {{1'b1,1'b1,F2,1'b0,X0,1'b1,F3}, C_NONE, W_RAW | W_WAR},
    {{1'b1,1'b1,F3,1'b0,X0,1'b1,F2}, C_NONE, W_WAW}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2: return "R4";
      3:       return "R7";
      4:       return "R2";
      5, 15:   return "R3";
      6, 12:   return "R6";
      7:       return "R8";
      8, 14:   return "R2";
      9, 11:   return "R10";
      10:      return "R11";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [21:0] iss, input logic [21:0] cmp,
                       input logic [3:0] exp, input string tag);
    {iss_vld, iss_a_use, iss_a, iss_b_use, iss_b, iss_d_use, iss_d} = iss;
    {cmp_vld, cmp_a_use, cmp_a, cmp_b_use, cmp_b, cmp_d_use, cmp_d} = cmp;
    #1;
    checks++;
    if ({stall, stall_why} !== {|exp, exp}) begin
      fails++;
      $display("FAIL %s: stall/why actual %b/%b expected %b/%b",
               tag, stall, stall_why, |exp, exp);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    {iss_vld, iss_a_use, iss_a, iss_b_use, iss_b, iss_d_use, iss_d} = '0;
    {cmp_vld, cmp_a_use, cmp_a, cmp_b_use, cmp_b, cmp_d_use, cmp_d} = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++)
      apply(TBL[i][47:26], TBL[i][25:4], TBL[i][3:0], vec_tag(i));

    // R1: F2 pending and F3 read before reset; both clear afterwards
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    apply({1'b1,1'b1,F2,1'b1,F3,1'b1,F3}, C_NONE, W_NONE, "R1");

    // R9: six reads of X8 accepted, the seventh hits the count guard
    for (int k = 0; k < 6; k++)
      apply({1'b1,1'b1,X8,1'b0,X0,1'b0,X0}, C_NONE, W_NONE, "R9");
    apply({1'b1,1'b1,X8,1'b0,X0,1'b0,X0}, C_NONE, W_FULL, "R9");

    // R5: write to X8 waits while readers retire one per cycle, same-cycle release (R6)
    for (int k = 0; k < 6; k++)
      apply({1'b1,1'b0,X0,1'b0,X0,1'b1,X8}, {1'b1,1'b1,X8,1'b0,X0,1'b0,X0},
            (k < 5) ? W_WAR : W_NONE, "R5");

    // R8: stalled writes left no pending flag; the accepted one did
    apply({1'b1,1'b1,X8,1'b0,X0,1'b0,X0}, C_NONE, W_RAW, "R8");
    // R7: floating-point register 8 unaffected by integer register 8
    apply({1'b1,1'b1,F8,1'b0,X0,1'b1,F8}, C_NONE, W_NONE, "R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule